// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that moves one byte at a time under software control. Software reaches it through four 8-bit registers: control, status, data and own-address. Writing the control register opens a transfer with a START, closes it with a STOP, or inserts a repeated START. Each byte is launched by a data-register access. In transmit mode that access is a write. In receive mode it is a read, which returns the byte received before and launches the next reception. Software then polls the completion flag in the status register and clears it by writing the status register.

The block pulls SCL and SDA low through two open-drain enables and samples both lines. One bit takes four quarter phases, and the phase advances once per pulse on the `tick` input, which comes from an external divider. A bus monitor watches the lines for START and STOP patterns and keeps a bus-busy flag from them.

Register map: control at address 0, status at 1, data at 2, own-address at 3. Reads return the value in bits 7:0 of the read word, and the upper bits read zero.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads zero and both line enables (`scl_oe`, `sda_oe`) are 0, so both lines are released.
- R2: Writing control bit 1 (master) as 1 together with control bit 0 (enable) as 1 while not master produces a START: SDA falls while SCL is released. Writing bit 1 as 0 while master produces a STOP: SDA rises while SCL is released. Control bit 1 reads back the master state.
- R3: Writing control bit 4 as 1 while master produces a repeated START with no STOP in between. Bit 4 always reads back 0.
- R4: In transmit mode (control bit 2 = 1), a data write while master sends the 8 bits MSB first, changing SDA only while SCL is held low. The block then samples the acknowledge bit into status bit 2, where 1 means no acknowledge.
- R5: Status bit 1 (done) goes to 1 at the end of every byte. A status write with bit 1 = 0 clears it, and the setting of the flag wins over a clear in the same cycle.
- R6: In receive mode (control bit 2 = 0), a data read while master returns the byte received before and launches a new reception. The first read after a switch to receive mode is therefore a dummy. A data read while not master only returns the stored byte.
- R7: The block answers a received byte with ACK (SDA low) when control bit 3 is 0, and with NACK (SDA released) when control bit 3 is 1.
- R8: Status bit 0 (busy) is 1 from a START detected on the bus until a STOP detected on the bus.
- R9: The own-address register stores bits 7:1 of a write and reads back bit 0 as 0, holding a 7-bit address shifted left by one.
- R10: A write that sets control bit 1 while control bit 0 is 0 has no effect on the bus and leaves the block out of master mode.
- R11: Address bytes go out as the 7-bit address followed by a direction bit, where 1 means read. A read from a slave with a repeated START returns the slave's bytes in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe from the divider |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read in receive mode has a side effect) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | BUS_W (32) | Read data in bits 7:0, upper bits zero |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with its defaults: 8-bit registers, a 32-bit read word and two synchronizer stages on the bus inputs. It pulses `tick` every fourth clock, so one byte with its acknowledge takes about 150 clocks. At that pace a complete write, a read with a repeated START and a NACKed address all fit in one short run against a slave model that holds two bytes of memory. The two synchronizer stages delay the busy flag by a few clocks behind the line events, and the bench looks at that flag only after polling the done flag, so the delay is covered.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the I2C master byte engine.
// Assumes 8-bit registers; bit positions are decoded by software.
package i2cm_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_OWN  = 2'd3;

    localparam int CB_EN    = 0;
    localparam int CB_MST   = 1;
    localparam int CB_TX    = 2;
    localparam int CB_NOACK = 3;
    localparam int CB_RSTA  = 4;

    localparam int SB_BUSY   = 0;
    localparam int SB_DONE   = 1;
    localparam int SB_NACKED = 2;

    typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_RESTART, CMD_BYTE} cmd_e;
    typedef enum logic [2:0] {ES_IDLE, ES_START, ES_STOP, ES_RSTART, ES_BITS} eng_st_e;
endpackage

// File: rtl/i2cm_bus_monitor.sv
`timescale 1ns/1ps
// Watches the I2C lines for START and STOP patterns and keeps a busy flag.
// Assumes the line inputs may be asynchronous; they pass a SYNC_STAGES chain.
module i2cm_bus_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_prev, sda_prev;
    logic scl_s, sda_s;

    // Synchronizer chains, reset to the idle (high) level.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync[i] <= 1'b1;
                    sda_sync[i] <= 1'b1;
                end else if (i == 0) begin
                    scl_sync[i] <= scl_in;
                    sda_sync[i] <= sda_in;
                end else begin
                    scl_sync[i] <= scl_sync[(i == 0) ? 0 : i-1];
                    sda_sync[i] <= sda_sync[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    // Decode SDA edges that happen while SCL stays high.
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;

    // Previous levels and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            busy     <= 1'b0;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
            if (start_det)     busy <= 1'b1;
            else if (stop_det) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_bit_engine.sv
`timescale 1ns/1ps
// Bit-level sequencer: generates START, STOP, repeated START and 9-clock
// byte frames on open-drain enables. Advances one quarter-bit per tick.
// Assumes commands arrive only while ready and no slave stretches SCL.
module i2cm_bit_engine
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  cmd_e              cmd_kind,
    input  logic              cmd_tx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              nack_rx,
    input  logic              sda_in,
    output logic              ready,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              done,
    output logic              done_rx,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ack_bit,
    output logic              in_bits,
    output logic              in_open
);
    localparam int BCW = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W);

    eng_st_e           state;
    logic [1:0]        ph;
    logic [BCW-1:0]    bitn;
    logic [DATA_W-1:0] shreg;
    logic              is_tx;
    logic              nack_q;

    assign ready   = (state == ES_IDLE);
    assign in_bits = (state == ES_BITS);
    assign in_open = (state == ES_START) || (state == ES_RSTART);
    assign done_rx = !is_tx;
    assign rx_byte = shreg;

    // Main sequencer: line levels, bit count and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ES_IDLE;
            ph      <= 2'd0;
            bitn    <= '0;
            shreg   <= '0;
            is_tx   <= 1'b0;
            nack_q  <= 1'b0;
            scl_lo  <= 1'b0;
            sda_lo  <= 1'b0;
            done    <= 1'b0;
            ack_bit <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ES_IDLE: begin
                    if (cmd_valid) begin
                        ph <= 2'd0;
                        case (cmd_kind)
                            CMD_START: begin
                                sda_lo <= 1'b1;
                                state  <= ES_START;
                            end
                            CMD_STOP: begin
                                scl_lo <= 1'b1;
                                sda_lo <= 1'b1;
                                state  <= ES_STOP;
                            end
                            CMD_RESTART: begin
                                scl_lo <= 1'b1;
                                sda_lo <= 1'b0;
                                state  <= ES_RSTART;
                            end
                            default: begin
                                shreg  <= cmd_data;
                                is_tx  <= cmd_tx;
                                nack_q <= nack_rx;
                                bitn   <= '0;
                                scl_lo <= 1'b1;
                                sda_lo <= cmd_tx & ~cmd_data[DATA_W-1];
                                state  <= ES_BITS;
                            end
                        endcase
                    end
                end
                ES_START: begin
                    if (tick) begin
                        scl_lo <= 1'b1;
                        state  <= ES_IDLE;
                    end
                end
                ES_STOP: begin
                    if (tick) begin
                        if (ph == 2'd0) begin
                            scl_lo <= 1'b0;
                            ph     <= 2'd1;
                        end else begin
                            sda_lo <= 1'b0;
                            state  <= ES_IDLE;
                        end
                    end
                end
                ES_RSTART: begin
                    if (tick) begin
                        case (ph)
                            2'd0:    begin scl_lo <= 1'b0; ph <= 2'd1; end
                            2'd1:    begin sda_lo <= 1'b1; ph <= 2'd2; end
                            default: begin scl_lo <= 1'b1; state <= ES_IDLE; end
                        endcase
                    end
                end
                ES_BITS: begin
                    if (tick) begin
                        case (ph)
                            2'd0: begin
                                scl_lo <= 1'b0;
                                ph     <= 2'd1;
                            end
                            2'd1: begin
                                if (bitn == LAST_BIT) ack_bit <= sda_in;
                                else shreg <= {shreg[DATA_W-2:0], sda_in};
                                ph <= 2'd2;
                            end
                            2'd2: begin
                                scl_lo <= 1'b1;
                                ph     <= 2'd3;
                            end
                            default: begin
                                if (bitn == LAST_BIT) begin
                                    done  <= 1'b1;
                                    state <= ES_IDLE;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                    ph   <= 2'd0;
                                    if (bitn == LAST_BIT - 1'b1)
                                        sda_lo <= is_tx ? 1'b0 : ~nack_q;
                                    else
                                        sda_lo <= is_tx & ~shreg[DATA_W-1];
                                end
                            end
                        endcase
                    end
                end
                default: state <= ES_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_regfile.sv
`timescale 1ns/1ps
// Register set and command slot. Turns register accesses into bus commands
// held in a one-entry slot until the bit engine is free. A newer command
// overwrites a pending one; software is expected to poll done between bytes.
module i2cm_regfile
    import i2cm_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              eng_ready,
    input  logic              eng_done,
    input  logic              eng_done_rx,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_ack,
    output logic              cmd_valid,
    output cmd_e              cmd_kind,
    output logic              cmd_tx,
    output logic [DATA_W-1:0] cmd_data,
    output logic              noack,
    output logic              done_flag
);
    localparam int PAD_W = BUS_W - DATA_W;

    logic              en_q, master_q, tx_q, nacked_q;
    logic [DATA_W-2:0] own_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rd_sel;

    // Register state, status flags and the command slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            master_q  <= 1'b0;
            tx_q      <= 1'b0;
            noack     <= 1'b0;
            nacked_q  <= 1'b0;
            done_flag <= 1'b0;
            own_q     <= '0;
            rx_q      <= '0;
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_START;
            cmd_tx    <= 1'b0;
            cmd_data  <= '0;
        end else begin
            if (cmd_valid && eng_ready) cmd_valid <= 1'b0;
            if (eng_done) begin
                done_flag <= 1'b1;
                if (eng_done_rx) rx_q <= eng_rx_byte;
                else nacked_q <= eng_ack;
            end
            if (reg_wr) begin
                case (reg_addr)
                    RA_CTRL: begin
                        en_q  <= reg_wdata[CB_EN];
                        tx_q  <= reg_wdata[CB_TX];
                        noack <= reg_wdata[CB_NOACK];
                        if (!master_q && reg_wdata[CB_MST] && reg_wdata[CB_EN]) begin
                            master_q  <= 1'b1;
                            cmd_valid <= 1'b1;
                            cmd_kind  <= CMD_START;
                        end else if (master_q && !reg_wdata[CB_MST]) begin
                            master_q  <= 1'b0;
                            cmd_valid <= 1'b1;
                            cmd_kind  <= CMD_STOP;
                        end else if (master_q && reg_wdata[CB_RSTA]) begin
                            cmd_valid <= 1'b1;
                            cmd_kind  <= CMD_RESTART;
                        end
                    end
                    RA_STAT: begin
                        if (!reg_wdata[SB_DONE] && !eng_done) done_flag <= 1'b0;
                    end
                    RA_DATA: begin
                        if (master_q && tx_q) begin
                            cmd_valid <= 1'b1;
                            cmd_kind  <= CMD_BYTE;
                            cmd_tx    <= 1'b1;
                            cmd_data  <= reg_wdata;
                        end
                    end
                    default: own_q <= reg_wdata[DATA_W-1:1];
                endcase
            end
            if (reg_rd && reg_addr == RA_DATA && master_q && !tx_q) begin
                cmd_valid <= 1'b1;
                cmd_kind  <= CMD_BYTE;
                cmd_tx    <= 1'b0;
                cmd_data  <= '1;
            end
        end
    end

    // Read multiplexer; value sits in the low byte.
    always_comb begin
        rd_sel = '0;
        case (reg_addr)
            RA_CTRL: begin
                rd_sel[CB_EN]    = en_q;
                rd_sel[CB_MST]   = master_q;
                rd_sel[CB_TX]    = tx_q;
                rd_sel[CB_NOACK] = noack;
            end
            RA_STAT: begin
                rd_sel[SB_BUSY]   = busy;
                rd_sel[SB_DONE]   = done_flag;
                rd_sel[SB_NACKED] = nacked_q;
            end
            RA_DATA: rd_sel = rx_q;
            default: rd_sel = {own_q, 1'b0};
        endcase
    end

    assign reg_rdata = {{PAD_W{1'b0}}, rd_sel};
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
// Top of the I2C master byte engine: register set, bit sequencer and bus
// monitor. Assumes external pull-ups and a tick of a quarter SCL period.
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic             mon_start, mon_stop, mon_busy;
    logic             cmd_valid, cmd_tx, noack, done_flag;
    cmd_e             cmd_kind;
    logic [REG_W-1:0] cmd_data, eng_rx_byte;
    logic             eng_ready, eng_done, eng_done_rx, eng_ack;
    logic             eng_bits, eng_open;

    i2cm_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_det(mon_start), .stop_det(mon_stop), .busy(mon_busy)
    );

    i2cm_regfile #(.BUS_W(BUS_W), .DATA_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(mon_busy), .eng_ready(eng_ready), .eng_done(eng_done),
        .eng_done_rx(eng_done_rx), .eng_rx_byte(eng_rx_byte), .eng_ack(eng_ack),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_tx(cmd_tx),
        .cmd_data(cmd_data), .noack(noack), .done_flag(done_flag)
    );

    i2cm_bit_engine #(.DATA_W(REG_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_tx(cmd_tx), .cmd_data(cmd_data),
        .nack_rx(noack), .sda_in(sda_in), .ready(eng_ready),
        .scl_lo(scl_oe), .sda_lo(sda_oe), .done(eng_done),
        .done_rx(eng_done_rx), .rx_byte(eng_rx_byte), .ack_bit(eng_ack),
        .in_bits(eng_bits), .in_open(eng_open)
    );
endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
// Protocol checker for i2c_byte_master, attached with bind.
module i2c_byte_master_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic byte_done,
    input logic done_flag,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic in_bits,
    input logic in_open
);
    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> done_flag);
    // R8
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);
    // R8
    busy_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !busy);
    // R4
    data_under_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bits && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));
    // R2
    sda_fall_only_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> in_open);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .byte_done(eng_done), .done_flag(done_flag), .start_det(mon_start),
    .stop_det(mon_stop), .busy(mon_busy), .in_bits(eng_bits), .in_open(eng_open)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
// Scoreboard bench with an I2C slave model holding two bytes at address 0x2A.
module sim_i2c_byte_master;
    localparam int BUS_W = 32;
    localparam logic [6:0] SLV = 7'h2A;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [7:0]       reg_wdata = 8'd0;
    logic [BUS_W-1:0] reg_rdata;
    logic             scl_oe, sda_oe;
    logic             sl_sda_lo = 1'b0;
    logic             scl_line, sda_line;
    logic [1:0]       tcnt = 2'd0;

    int n_cmp = 0, n_bad = 0;
    typedef struct { string req; logic [7:0] val; } exp_t;
    exp_t exp_q[$];

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | sl_sda_lo);

    i2c_byte_master #(.BUS_W(BUS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;

    // Quarter-bit strobe every fourth clock.
    always @(posedge clk) begin
        tcnt <= tcnt + 2'd1;
        tick <= (tcnt == 2'd3);
    end

    // Slave model state.
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         sst = 0, bitc = 0;
    logic [7:0] sh = 8'd0, got_addr = 8'd0;
    logic       rw = 1'b0, first_wr = 1'b0, ptr = 1'b0, mack = 1'b0;
    logic [7:0] mem [2];
    int         m_acks = 0, m_nacks = 0;

    // Slave: reacts to line edges; changes SDA only while SCL is low.
    always @(scl_line or sda_line) begin
        if (scl_line === 1'b1 && prev_scl === 1'b1 && sda_line !== prev_sda) begin
            if (sda_line === 1'b0) begin sst = 1; bitc = 0; sl_sda_lo = 1'b0; end
            else if (sda_line === 1'b1) begin sst = 0; sl_sda_lo = 1'b0; end
        end else if (scl_line === 1'b1 && prev_scl === 1'b0 && sst != 0) begin
            if (bitc < 8) begin
                if (sst != 3) sh = {sh[6:0], sda_line};
            end else if (sst == 3) begin
                mack = (sda_line === 1'b0);
                if (mack) m_acks++; else m_nacks++;
            end
            bitc++;
        end else if (scl_line === 1'b0 && prev_scl === 1'b1 && sst != 0) begin
            if (bitc == 8) begin
                if (sst == 1) begin
                    got_addr = sh;
                    if (sh[7:1] == SLV) begin rw = sh[0]; sl_sda_lo = 1'b1; end
                    else sst = 0;
                end else if (sst == 2) begin
                    if (first_wr) begin ptr = sh[0]; first_wr = 1'b0; end
                    else begin mem[ptr] = sh; ptr = ~ptr; end
                    sl_sda_lo = 1'b1;
                end else sl_sda_lo = 1'b0;
            end else if (bitc == 9) begin
                bitc = 0;
                if (sst == 1) begin
                    if (rw) begin sst = 3; sh = mem[ptr]; ptr = ~ptr; sl_sda_lo = ~sh[7]; end
                    else begin sst = 2; first_wr = 1'b1; sl_sda_lo = 1'b0; end
                end else if (sst == 2) sl_sda_lo = 1'b0;
                else if (mack) begin sh = mem[ptr]; ptr = ~ptr; sl_sda_lo = ~sh[7]; end
                else begin sst = 0; sl_sda_lo = 1'b0; end
            end else if (sst == 3) sl_sda_lo = ~sh[7-bitc];
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // Driver side: queue an expected item.
    task automatic push_exp(input string req, input logic [7:0] v);
        exp_q.push_back('{req, v});
    endtask

    // Monitor side: pop the oldest expected item and compare.
    task automatic observe(input logic [7:0] act);
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (act !== e.val) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", e.req, act, e.val);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata[7:0];
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Poll done (status bit 1), return the status seen, then clear it.
    task automatic wait_done(output logic [7:0] st);
        st = 8'd0;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, st);
            if (st[1]) break;
        end
        wr(2'd1, 8'd0);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        logic [7:0] v;
        mem[0] = 8'h00; mem[1] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        push_exp("R1 ctrl", 8'h00);   rd(2'd0, v); observe(v);
        push_exp("R1 status", 8'h00); rd(2'd1, v); observe(v);
        push_exp("R1 data", 8'h00);   rd(2'd2, v); observe(v);
        push_exp("R1 own", 8'h00);    rd(2'd3, v); observe(v);
        push_exp("R1 lines", 8'h00);  observe({6'd0, scl_oe, sda_oe});

        // R9: own address keeps bits 7:1
        wr(2'd3, 8'h55);
        push_exp("R9 own", 8'h54); rd(2'd3, v); observe(v);

        // R10: start without enable is ignored
        wr(2'd0, 8'h02);
        repeat (60) @(negedge clk);
        push_exp("R10 lines", 8'h00); observe({6'd0, scl_oe, sda_oe});
        push_exp("R10 ctrl", 8'h00);  rd(2'd0, v); observe(v);
        push_exp("R10 busy", 8'h00);  rd(2'd1, v); observe(v & 8'h01);

        // Write: START, addr+W, pointer 0, A5, 3C, STOP
        wr(2'd0, 8'h07);
        wr(2'd2, {SLV, 1'b0});
        wait_done(v);
        push_exp("R2 R4 R8 addr acked busy done", 8'h03); observe(v);
        push_exp("R2 ctrl master", 8'h07); rd(2'd0, v); observe(v);
        push_exp("R5 done cleared", 8'h01); rd(2'd1, v); observe(v);
        push_exp("R4 R11 addr byte MSB first", {SLV, 1'b0}); observe(got_addr);
        wr(2'd2, 8'h00); wait_done(v);
        wr(2'd2, 8'hA5); wait_done(v);
        wr(2'd2, 8'h3C); wait_done(v);
        push_exp("R4 data acked", 8'h03); observe(v);
        wr(2'd0, 8'h05);
        wait_idle();
        push_exp("R2 R8 after stop", 8'h00); rd(2'd1, v); observe(v);
        push_exp("R4 mem0", 8'hA5); observe(mem[0]);
        push_exp("R4 mem1", 8'h3C); observe(mem[1]);

        // Read with repeated START
        wr(2'd0, 8'h07);
        wr(2'd2, {SLV, 1'b0}); wait_done(v);
        wr(2'd2, 8'h00);       wait_done(v);
        wr(2'd0, 8'h17);
        push_exp("R3 restart bit reads 0", 8'h07); rd(2'd0, v); observe(v);
        wr(2'd2, {SLV, 1'b1}); wait_done(v);
        push_exp("R3 R11 read addr acked, still busy", 8'h03); observe(v);
        push_exp("R11 read addr byte", {SLV, 1'b1}); observe(got_addr);
        wr(2'd0, 8'h03);
        rd(2'd2, v);           wait_done(v);
        push_exp("R6 rx done", 8'h03); observe(v & 8'h03);
        wr(2'd0, 8'h0B);
        rd(2'd2, v);
        push_exp("R6 first byte", 8'hA5); observe(v);
        wait_done(v);
        wr(2'd0, 8'h01);
        wait_idle();
        rd(2'd2, v);
        push_exp("R6 R11 second byte", 8'h3C); observe(v);
        push_exp("R7 master acks", 8'h01);  observe(8'(m_acks));
        push_exp("R7 master nacks", 8'h01); observe(8'(m_nacks));
        push_exp("R6 no launch when not master", 8'h3C); rd(2'd2, v); observe(v);

        // NACKed address
        wr(2'd0, 8'h07);
        wr(2'd2, {7'h11, 1'b0}); wait_done(v);
        push_exp("R4 address nacked", 8'h07); observe(v);
        wr(2'd0, 8'h05);
        wait_idle();
        push_exp("R8 idle after nack stop", 8'h04); rd(2'd1, v); observe(v);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule